// File: doc/BRIEF.md
# Low-Power Mode Entry and Exit Sequencer

This block moves a system into one of three reduced-power states and brings it back. A two-bit mode request selects processor-only clock gating (idle), slow-clock retention (retention 0) or all-clocks-off retention (retention 1). The block then drives eight ordered step outputs to the memory controller, peripheral clock gates, I/O and USB transceiver controls, system clock mux, SRAM light-sleep enables, PLL and oscillator enables, and the CPU clock gate or deep-mode entry bit. Each step is a four-phase handshake with its own acknowledge bit, so analog parts and the memory controller can be modelled as request/acknowledge stubs.

Once a mode is reached, the block waits for the wake set of that mode. Idle and retention 0 wake on the interrupt line. Retention 1 wakes only on an enabled wake-pin level change, an RTC/RTT alarm, a USB resume or a wake-on-LAN event. On a wake, the block releases the applied steps in a fixed order. SRAM light sleep is released right after the final step, ahead of clock and oscillator restore. A wake that arrives during entry aborts the entry and unwinds what was applied. A step whose acknowledge does not follow its request within a timeout raises an error flag.

Top module: `lowpower_seq`

## Requirements
- R1: After reset every step output is low, `sysclk_sel` is 00, `busy` is low and `seq_err` is low.
- R2: A request is accepted only when `req_vld` is high and `busy` is low. The encodings are `mode_req` 01 idle, 10 retention 0 and 11 retention 1. Code 00, and any request made while busy, is ignored. `busy` rises on the cycle after acceptance and falls on the cycle the last step is released, with all step outputs low.
- R3: In both retention modes the steps are raised one at a time in index order. Each step raises only after the previous acknowledge is high. The indexes are: 0 self-refresh, 1 wake arm, 2 peripheral clock gate, 3 I/O park, 4 clock switch, 5 SRAM light sleep, 6 PLL/oscillator off, 7 final step. `step_ack[i]` acknowledges step i.
- R4: In retention 0, `sysclk_sel` is 01 (slow clock) while step 4 is applied, `rc_off` is raised with step 6, and the final step is `cpu_clk_gate`. Only `irq_wake` ends the mode.
- R5: In retention 1, `sysclk_sel` is 10 (RC oscillator) and `rc_off` stays low. The final step is `deep_entry`, which completes on the master-clock-ready acknowledge `step_ack[7]`. `irq_wake` is ignored. An enabled pin change, `rtc_alarm`, `usb_resume` or `lan_wake` ends the mode.
- R6: A wake pin counts only on a level change (rise or fall) while its bit in `wk_pin_en` is set. Changes on disabled pins are ignored.
- R7: Idle raises only step 7 as `cpu_clk_gate`, leaves all other step outputs low, and ends on `irq_wake`.
- R8: SRAM bank `KEEP_BANK` is never put into light sleep. All other banks follow step 5.
- R9: Exit drops one step at a time, each after its acknowledge falls. The order is step 7 first, then step 5, then the remaining applied steps from highest to lowest index.
- R10: A wake of the selected mode's set during entry aborts entry. The step in progress counts as applied, and all applied steps are released in the R9 order.
- R11: A step whose acknowledge does not reach the wanted level within `TIMEOUT` cycles sets `seq_err`. During entry the applied steps are then unwound. During exit all remaining steps drop at once and the block returns to run. `seq_err` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode (00 run, 01 idle, 10 retention 0, 11 retention 1) |
| irq_wake | input | 1 | Any enabled interrupt pending |
| wk_pin | input | NPIN | Dedicated wake pins |
| wk_pin_en | input | NPIN | Per-pin wake enable |
| rtc_alarm | input | 1 | RTC/RTT alarm wake |
| usb_resume | input | 1 | USB resume wake |
| lan_wake | input | 1 | Wake-on-LAN event |
| step_ack | input | 8 | Per-step acknowledge, bit i for step i |
| busy | output | 1 | Sequence in progress or mode held |
| seq_err | output | 1 | Step timeout seen since the last accepted request |
| mem_selfref | output | 1 | Step 0: memory self-refresh request |
| wake_arm | output | 1 | Step 1: wake sources armed |
| pclk_gate | output | 1 | Step 2: gate all peripheral clocks |
| io_park | output | 1 | Step 3: park I/Os, disable USB transceivers |
| sysclk_sel | output | 2 | Step 4: system clock select (00 main, 01 slow, 10 RC) |
| sram_ls | output | NBANK | Step 5: per-bank SRAM light sleep |
| pll_osc_off | output | 1 | Step 6: PLLs and main oscillator off |
| rc_off | output | 1 | Step 6, retention 0 only: RC oscillator off |
| cpu_clk_gate | output | 1 | Step 7, idle and retention 0: CPU clock gated |
| deep_entry | output | 1 | Step 7, retention 1: deep-mode entry bit |

## Verification
A wrong applied-step mask shows at the ports in the cycle after the faulty edge. Either a step output rises out of order, or a released step reappears, or the fall order breaks the final-then-SRAM-then-descending rule. The stub acknowledges echo the outputs one cycle later, so a wrong ordering in the exit pick spreads through the whole unwind and is caught against an order the bench computes from the set of applied steps. A mode register or wake-select fault shows as a wrong clock-select code, a stray `rc_off`, or a held mode that leaves on the wrong source or fails to leave within a few cycles. A timer fault shows as a missing `seq_err` or a wrong count of steps raised before the abort.

// File: rtl/lps_pkg.sv
`timescale 1ns/1ps
package lps_pkg;
   localparam int unsigned NSTEP = 8;

   // step indexes; their order is the entry order
   localparam int unsigned ST_SELFREF = 0;
   localparam int unsigned ST_ARM     = 1;
   localparam int unsigned ST_PCLK    = 2;
   localparam int unsigned ST_IO      = 3;
   localparam int unsigned ST_CLKSW   = 4;
   localparam int unsigned ST_SRAM    = 5;
   localparam int unsigned ST_OSC     = 6;
   localparam int unsigned ST_FINAL   = 7;

   typedef enum logic [1:0] {
      PH_RUN   = 2'd0,
      PH_ENTER = 2'd1,
      PH_HOLD  = 2'd2,
      PH_EXIT  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      MD_RUN  = 2'b00,
      MD_IDLE = 2'b01,
      MD_RET0 = 2'b10,
      MD_RET1 = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      CK_MAIN = 2'b00,
      CK_SLOW = 2'b01,
      CK_RC   = 2'b10
   } clksel_e;
endpackage

// File: rtl/lps_wake_detect.sv
`timescale 1ns/1ps
module lps_wake_detect #(
   parameter int unsigned NPIN = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin,
   input  logic [NPIN-1:0] pin_en,
   input  logic            rtc_alarm,
   input  logic            usb_resume,
   input  logic            lan_wake,
   output logic            deep_wake
);
   logic [NPIN-1:0] pin_q;
   logic [NPIN-1:0] pin_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin;
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign pin_hit[i] = pin_en[i] & (pin[i] ^ pin_q[i]);
   end

   assign deep_wake = (|pin_hit) | rtc_alarm | usb_resume | lan_wake;
endmodule

// File: rtl/lps_step_timer.sv
`timescale 1ns/1ps
module lps_step_timer #(
   parameter int unsigned TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic restart,
   output logic expired
);
   localparam int unsigned CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (restart || !active) cnt_q <= '0;
      else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
   end

   assign expired = active && (cnt_q == LAST);
endmodule

// File: rtl/lps_step_pick.sv
`timescale 1ns/1ps
module lps_step_pick
   import lps_pkg::*;
(
   input  logic [NSTEP-1:0] need,
   input  logic [NSTEP-1:0] done,
   output logic [NSTEP-1:0] cur_oh,
   output logic [NSTEP-1:0] pick_oh
);
   // lowest pending step is the next one to apply
   always_comb begin
      cur_oh = '0;
      for (int i = NSTEP - 1; i >= 0; i--) begin
         if (need[i]) cur_oh = NSTEP'(1) << i;
      end
   end

   // release: final step, then SRAM light sleep, then highest index
   always_comb begin
      pick_oh = '0;
      if (done[ST_FINAL])     pick_oh = NSTEP'(1) << ST_FINAL;
      else if (done[ST_SRAM]) pick_oh = NSTEP'(1) << ST_SRAM;
      else begin
         for (int i = 0; i < NSTEP; i++) begin
            if (done[i]) pick_oh = NSTEP'(1) << i;
         end
      end
   end
endmodule

// File: rtl/lowpower_seq.sv
`timescale 1ns/1ps
module lowpower_seq
   import lps_pkg::*;
#(
   parameter int unsigned NPIN      = 14,
   parameter int unsigned NBANK     = 8,
   parameter int unsigned KEEP_BANK = 6,
   parameter int unsigned TIMEOUT   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [1:0]       mode_req,
   input  logic             irq_wake,
   input  logic [NPIN-1:0]  wk_pin,
   input  logic [NPIN-1:0]  wk_pin_en,
   input  logic             rtc_alarm,
   input  logic             usb_resume,
   input  logic             lan_wake,
   input  logic [7:0]       step_ack,
   output logic             busy,
   output logic             seq_err,
   output logic             mem_selfref,
   output logic             wake_arm,
   output logic             pclk_gate,
   output logic             io_park,
   output logic [1:0]       sysclk_sel,
   output logic [NBANK-1:0] sram_ls,
   output logic             pll_osc_off,
   output logic             rc_off,
   output logic             cpu_clk_gate,
   output logic             deep_entry
);
   if (KEEP_BANK >= NBANK) begin : g_bad_keep
      $error("KEEP_BANK must index an existing SRAM bank");
   end
   if (NPIN < 1) begin : g_bad_npin
      $error("NPIN must be at least 1");
   end
   if (TIMEOUT < 2) begin : g_bad_tmo
      $error("TIMEOUT must be at least 2");
   end

   phase_e           phase_q, phase_d;
   mode_e            mode_q, mode_d;
   logic [NSTEP-1:0] done_q, done_d;
   logic             err_q, err_d;

   logic [NSTEP-1:0] mode_mask, need, cur_oh, pick_oh, step_lvl;
   logic             deep_wake, wake, tmo, cur_ack, pick_ack, adv;

   lps_wake_detect #(.NPIN(NPIN)) wake_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (wk_pin),
      .pin_en     (wk_pin_en),
      .rtc_alarm  (rtc_alarm),
      .usb_resume (usb_resume),
      .lan_wake   (lan_wake),
      .deep_wake  (deep_wake)
   );

   lps_step_pick pick_i (
      .need    (need),
      .done    (done_q),
      .cur_oh  (cur_oh),
      .pick_oh (pick_oh)
   );

   lps_step_timer #(.TIMEOUT(TIMEOUT)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (phase_q == PH_ENTER || phase_q == PH_EXIT),
      .restart (adv || (phase_d != phase_q)),
      .expired (tmo)
   );

   always_comb begin
      case (mode_q)
         MD_IDLE:          mode_mask = NSTEP'(1) << ST_FINAL;
         MD_RET0, MD_RET1: mode_mask = '1;
         default:          mode_mask = '0;
      endcase
   end

   assign need     = mode_mask & ~done_q;
   assign wake     = (mode_q == MD_RET1) ? deep_wake : irq_wake;
   assign cur_ack  = |(cur_oh & step_ack);
   assign pick_ack = |(pick_oh & step_ack);
   assign adv      = (phase_q == PH_ENTER && cur_ack) ||
                     (phase_q == PH_EXIT && !pick_ack);

   always_comb begin
      phase_d = phase_q;
      mode_d  = mode_q;
      done_d  = done_q;
      err_d   = err_q;
      case (phase_q)
         PH_RUN: begin
            if (req_vld && mode_req != MD_RUN) begin
               phase_d = PH_ENTER;
               mode_d  = mode_e'(mode_req);
               err_d   = 1'b0;
            end
         end
         PH_ENTER: begin
            if (wake || tmo) begin
               done_d  = done_q | cur_oh;
               phase_d = PH_EXIT;
               err_d   = err_q | tmo;
            end else if (cur_ack) begin
               done_d = done_q | cur_oh;
               if ((need & ~cur_oh) == '0) phase_d = PH_HOLD;
            end
         end
         PH_HOLD: begin
            if (wake) phase_d = PH_EXIT;
         end
         default: begin
            if (tmo) begin
               done_d  = '0;
               phase_d = PH_RUN;
               err_d   = 1'b1;
            end else if (!pick_ack) begin
               done_d = done_q & ~pick_oh;
               if ((done_q & ~pick_oh) == '0) phase_d = PH_RUN;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         mode_q  <= MD_RUN;
         done_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         mode_q  <= mode_d;
         done_q  <= done_d;
         err_q   <= err_d;
      end
   end

   assign step_lvl = (done_q | ((phase_q == PH_ENTER) ? cur_oh : '0)) &
                     ~((phase_q == PH_EXIT) ? pick_oh : '0);

   assign busy        = (phase_q != PH_RUN);
   assign seq_err     = err_q;
   assign mem_selfref = step_lvl[ST_SELFREF];
   assign wake_arm    = step_lvl[ST_ARM];
   assign pclk_gate   = step_lvl[ST_PCLK];
   assign io_park     = step_lvl[ST_IO];
   assign sysclk_sel  = !step_lvl[ST_CLKSW]  ? CK_MAIN :
                        (mode_q == MD_RET0) ? CK_SLOW : CK_RC;
   assign pll_osc_off  = step_lvl[ST_OSC];
   assign rc_off       = step_lvl[ST_OSC] && (mode_q == MD_RET0);
   assign cpu_clk_gate = step_lvl[ST_FINAL] && (mode_q != MD_RET1);
   assign deep_entry   = step_lvl[ST_FINAL] && (mode_q == MD_RET1);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      if (b == KEEP_BANK) begin : g_keep
         assign sram_ls[b] = 1'b0;
      end else begin : g_sleep
         assign sram_ls[b] = step_lvl[ST_SRAM];
      end
   end
endmodule

// File: rtl/lowpower_seq_chk.sv
`timescale 1ns/1ps
module lowpower_seq_chk #(
   parameter int unsigned NBANK = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             mem_selfref,
   input logic             wake_arm,
   input logic             pclk_gate,
   input logic             io_park,
   input logic [1:0]       sysclk_sel,
   input logic [NBANK-1:0] sram_ls,
   input logic             pll_osc_off,
   input logic             rc_off,
   input logic             cpu_clk_gate,
   input logic             deep_entry
);
   // R3
   arm_after_selfref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_arm) |-> (mem_selfref && !pclk_gate));

   // R3
   osc_after_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_osc_off) |-> ((|sram_ls) && sysclk_sel != 2'b00));

   // R9
   sram_before_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_osc_off) |-> (sram_ls == '0));

   // R9
   sram_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sysclk_sel) != 2'b00 && sysclk_sel == 2'b00) |-> (sram_ls == '0));

   // R4
   rc_only_on_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rc_off |-> (sysclk_sel == 2'b01));

   // R5
   final_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_clk_gate && deep_entry));

   // R2
   clean_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !(mem_selfref || wake_arm || pclk_gate || io_park ||
                        (|sram_ls) || pll_osc_off || cpu_clk_gate ||
                        deep_entry || sysclk_sel != 2'b00));

   // R2
   step_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_selfref || cpu_clk_gate || deep_entry || rc_off) |-> busy);
endmodule

bind lowpower_seq lowpower_seq_chk #(.NBANK(NBANK)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .mem_selfref  (mem_selfref),
   .wake_arm     (wake_arm),
   .pclk_gate    (pclk_gate),
   .io_park      (io_park),
   .sysclk_sel   (sysclk_sel),
   .sram_ls      (sram_ls),
   .pll_osc_off  (pll_osc_off),
   .rc_off       (rc_off),
   .cpu_clk_gate (cpu_clk_gate),
   .deep_entry   (deep_entry)
);

// File: tb/lowpower_seq_tb_top.sv
`timescale 1ns/1ps
module lowpower_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NPIN  = 14;
   localparam int NBANK = 8;
   localparam int KEEP  = 6;
   localparam int TMO   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic             req_vld = 1'b0;
   logic [1:0]       mode_req = 2'b00;
   logic             irq_wake = 1'b0;
   logic [NPIN-1:0]  wk_pin = '0;
   logic [NPIN-1:0]  wk_pin_en = '0;
   logic             rtc_alarm = 1'b0;
   logic             usb_resume = 1'b0;
   logic             lan_wake = 1'b0;
   logic [7:0]       step_ack;
   logic             busy, seq_err, mem_selfref, wake_arm, pclk_gate, io_park;
   logic [1:0]       sysclk_sel;
   logic [NBANK-1:0] sram_ls;
   logic             pll_osc_off, rc_off, cpu_clk_gate, deep_entry;

   lowpower_seq #(.NPIN(NPIN), .NBANK(NBANK), .KEEP_BANK(KEEP), .TIMEOUT(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode_req(mode_req),
      .irq_wake(irq_wake), .wk_pin(wk_pin), .wk_pin_en(wk_pin_en),
      .rtc_alarm(rtc_alarm), .usb_resume(usb_resume), .lan_wake(lan_wake),
      .step_ack(step_ack), .busy(busy), .seq_err(seq_err),
      .mem_selfref(mem_selfref), .wake_arm(wake_arm), .pclk_gate(pclk_gate),
      .io_park(io_park), .sysclk_sel(sysclk_sel), .sram_ls(sram_ls),
      .pll_osc_off(pll_osc_off), .rc_off(rc_off),
      .cpu_clk_gate(cpu_clk_gate), .deep_entry(deep_entry)
   );

   // step levels seen at the ports, bit i = step i
   logic [7:0] lvl;
   assign lvl = {cpu_clk_gate | deep_entry, pll_osc_off, |sram_ls,
                 sysclk_sel != 2'b00, io_park, pclk_gate, wake_arm, mem_selfref};

   // acknowledge stubs: echo each request one cycle later
   logic [7:0] stuck_lo = '0;
   logic [7:0] stuck_hi = '0;
   always @(negedge clk) begin
      if (!rst_n) step_ack <= '0;
      else        step_ack <= (lvl | stuck_hi) & ~stuck_lo;
   end

   // event log of rises and falls
   int rise_log [16];
   int fall_log [16];
   int rise_n, fall_n, max_up;
   int clr_gen = 0;
   int clr_seen = 0;
   logic [7:0] lvl_prev = '0;
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (clr_gen != clr_seen) begin
         clr_seen = clr_gen;
         rise_n = 0;
         fall_n = 0;
         max_up = 0;
      end
      for (int i = 0; i < 8; i++) begin
         if (lvl[i] && !lvl_prev[i] && rise_n < 16) begin rise_log[rise_n] = i; rise_n++; end
         if (!lvl[i] && lvl_prev[i] && fall_n < 16) begin fall_log[fall_n] = i; fall_n++; end
      end
      if ($countones(lvl) > max_up) max_up = $countones(lvl);
      lvl_prev = lvl;
   end

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic req(input logic [1:0] m);
      clr_gen++;
      req_vld = 1'b1;
      mode_req = m;
      @(negedge clk);
      req_vld = 1'b0;
      mode_req = 2'b00;
   endtask

   task automatic wait_lvl(input logic [7:0] target, input int maxc);
      int c = 0;
      while (lvl != target && c < maxc) begin @(negedge clk); c++; end
   endtask

   task automatic wait_free(input int maxc);
      int c = 0;
      while (busy && c < maxc) begin @(negedge clk); c++; end
      @(negedge clk);
   endtask

   // expected release order over a set of applied steps
   function automatic int exp_fall(input logic [7:0] set, input int pos);
      logic [7:0] s;
      int r;
      s = set;
      r = -1;
      for (int p = 0; p <= pos; p++) begin
         if (s[7]) r = 7;
         else if (s[5]) r = 5;
         else begin
            r = -1;
            for (int i = 0; i < 8; i++) if (s[i]) r = i;
         end
         if (r >= 0) s[r] = 1'b0;
      end
      return r;
   endfunction

   task automatic chk_falls(input logic [7:0] set, input string tag);
      chk(fall_n == $countones(set), tag, fall_n, $countones(set));
      for (int p = 0; p < $countones(set); p++)
         chk(fall_log[p] == exp_fall(set, p), tag, fall_log[p], exp_fall(set, p));
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lvl == 8'h00, "R1 step outputs", lvl, 0);
      chk(!busy && !seq_err, "R1 busy/err", {busy, seq_err}, 0);
      chk(sysclk_sel == 2'b00 && sram_ls == '0, "R1 clk/sram", sysclk_sel, 0);

      // R2 code 00 ignored
      req(2'b00);
      repeat (3) @(negedge clk);
      chk(!busy && lvl == 0, "R2 code 00 ignored", busy, 0);

      // retention 0 entry
      req(2'b10);
      chk(busy, "R2 busy after accept", busy, 1);
      wait_lvl(8'hFF, 40);
      chk(rise_n == 8, "R3 rise count", rise_n, 8);
      for (int p = 0; p < 8; p++) chk(rise_log[p] == p, "R3 entry order", rise_log[p], p);
      chk(sysclk_sel == 2'b01, "R4 slow clock", sysclk_sel, 1);
      chk(rc_off && cpu_clk_gate && !deep_entry, "R4 rc_off/cpu gate", {rc_off, cpu_clk_gate, deep_entry}, 3'b110);
      chk(sram_ls == NBANK'(~(1 << KEEP)), "R8 keep bank awake", sram_ls, NBANK'(~(1 << KEEP)));
      // R2 request while busy ignored
      req(2'b11);
      repeat (3) @(negedge clk);
      chk(lvl == 8'hFF && !deep_entry, "R2 busy request ignored", deep_entry, 0);
      // R4 only the interrupt wakes retention 0
      wk_pin_en = '1;
      wk_pin[0] = 1'b1;
      @(negedge clk); rtc_alarm = 1'b1; usb_resume = 1'b1; lan_wake = 1'b1;
      @(negedge clk); rtc_alarm = 1'b0; usb_resume = 1'b0; lan_wake = 1'b0;
      repeat (3) @(negedge clk);
      chk(lvl == 8'hFF && busy, "R4 deep sources ignored", lvl, 8'hFF);
      wk_pin[0] = 1'b0;
      @(negedge clk);
      wk_pin_en = '0;
      clr_gen++;
      irq_wake = 1'b1;
      wait_free(40);
      irq_wake = 1'b0;
      chk(!busy && lvl == 0, "R9 returned to run", lvl, 0);
      chk_falls(8'hFF, "R9 exit order ret0");

      // retention 1
      req(2'b11);
      wait_lvl(8'hFF, 40);
      chk(sysclk_sel == 2'b10, "R5 RC clock", sysclk_sel, 2);
      chk(!rc_off && deep_entry && !cpu_clk_gate, "R5 deep entry", {rc_off, deep_entry, cpu_clk_gate}, 3'b010);
      chk(sram_ls[KEEP] == 1'b0, "R8 keep bank ret1", sram_ls[KEEP], 0);
      irq_wake = 1'b1; @(negedge clk); irq_wake = 1'b0;
      wk_pin[3] = 1'b1;
      repeat (4) @(negedge clk);
      chk(lvl == 8'hFF && busy, "R5 irq ignored, R6 disabled pin ignored", lvl, 8'hFF);
      wk_pin[3] = 1'b0;
      @(negedge clk);
      chk(lvl == 8'hFF, "R6 disabled pin fall ignored", lvl, 8'hFF);
      wk_pin_en[5] = 1'b1;
      repeat (2) @(negedge clk);
      chk(lvl == 8'hFF, "R6 enable without change ignored", lvl, 8'hFF);
      clr_gen++;
      wk_pin[5] = 1'b1;
      wait_free(40);
      chk(!busy, "R6 pin rise wakes", busy, 0);
      chk_falls(8'hFF, "R9 exit order ret1");
      for (int src = 1; src < 5; src++) begin
         req(2'b11);
         wait_lvl(8'hFF, 40);
         clr_gen++;
         case (src)
            1: wk_pin[5] = 1'b0;
            2: rtc_alarm = 1'b1;
            3: usb_resume = 1'b1;
            default: lan_wake = 1'b1;
         endcase
         @(negedge clk);
         rtc_alarm = 1'b0; usb_resume = 1'b0; lan_wake = 1'b0;
         wait_free(40);
         chk(!busy && lvl == 0, "R5 wake source", src, 0);
         chk_falls(8'hFF, "R9 exit order ret1 source");
      end
      wk_pin_en = '0;

      // idle
      req(2'b01);
      wait_lvl(8'h80, 20);
      chk(cpu_clk_gate && lvl == 8'h80, "R7 idle gates cpu only", lvl, 8'h80);
      chk(rise_n == 1 && rise_log[0] == 7, "R7 single step", rise_n, 1);
      rtc_alarm = 1'b1; @(negedge clk); rtc_alarm = 1'b0;
      repeat (2) @(negedge clk);
      chk(lvl == 8'h80, "R7 idle ignores alarm", lvl, 8'h80);
      irq_wake = 1'b1;
      wait_free(20);
      irq_wake = 1'b0;
      chk(!busy && fall_n == 1 && fall_log[0] == 7, "R7 idle wake", fall_n, 1);

      // R10 abort sweep
      for (int k = 1; k <= 8; k++) begin
         logic [7:0] set;
         set = 8'((1 << k) - 1);
         req(2'b10);
         wait_lvl(set, 40);
         irq_wake = 1'b1;
         wait_free(60);
         irq_wake = 1'b0;
         chk(max_up == k, "R10 steps before abort", max_up, k);
         chk(!busy && lvl == 0 && !seq_err, "R10 unwound", lvl, 0);
         chk_falls(set, "R10 unwind order");
      end

      // R11 stuck-low acknowledge sweep
      for (int j = 0; j < 8; j++) begin
         stuck_lo = 8'(1 << j);
         req(2'b10);
         wait_free(200);
         chk(seq_err == 1'b1, "R11 entry timeout flag", seq_err, 1);
         chk(!busy && lvl == 0, "R11 entry unwound", lvl, 0);
         chk(max_up == j + 1, "R11 steps before timeout", max_up, j + 1);
         stuck_lo = '0;
      end
      req(2'b01);
      chk(!seq_err && busy, "R11 flag cleared on accept", seq_err, 0);
      wait_lvl(8'h80, 20);
      irq_wake = 1'b1; wait_free(20); irq_wake = 1'b0;

      // R11 stuck-high acknowledge on step 3 during exit
      stuck_hi = 8'h08;
      req(2'b10);
      wait_lvl(8'hFF, 40);
      clr_gen++;
      irq_wake = 1'b1;
      wait_free(200);
      irq_wake = 1'b0;
      stuck_hi = '0;
      chk(seq_err && !busy && lvl == 0, "R11 exit timeout to run", {seq_err, busy}, 2);
      chk(fall_n == 8, "R11 exit timeout fall count", fall_n, 8);
      chk(fall_log[0] == 7 && fall_log[1] == 5 && fall_log[2] == 6 && fall_log[3] == 4,
          "R11 exit order before timeout", fall_log[1], 5);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule